// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the configuration and pending state of a small set of interrupt sources and picks, for each of several CPUs, which interrupt should be presented next. Software reaches every piece of state through a 32-bit register bus that carries a word address, write data, byte strobes and separate read and write strobes. Peripheral interrupt lines enter directly, and a dedicated register lets software raise software interrupts towards a chosen list of CPUs.

Source IDs 0 to 15 are software interrupts, and each CPU keeps its own pending copy of them. IDs from 16 up are peripheral sources, each with one shared pending bit and an 8-bit CPU target mask. Every source also has an enable bit, a group bit and an 8-bit priority. Each CPU output port carries the winning ID and its priority. The port shows 1023 when nothing qualifies. The source count must be a multiple of 32, and the CPU count lies between 1 and 8.

An asynchronous active-low reset is released through a two-stage synchronizer, so the block comes out of reset two clock edges after `rst_n` rises.

Top module: `irqdist_top`

## Requirements
- R1: After reset, every register reads zero apart from the type word, every CPU port shows ID 1023 with priority 0xFF, and read data is zero.
- R2: Byte offset 0x000 is the group-enable control: bit 0 enables group 0, bit 1 enables group 1, and the other bits read zero. Offset 0x004 reads the source words minus one in bits 4:0 and the CPU count minus one in bits 7:5.
- R3: Offset 0x080+4n holds the group bits of sources 32n..32n+31, one bit per source (0 = group 0, 1 = group 1). Only bytes whose strobe is set are written. A source is forwarded only while its group is enabled in the control register.
- R4: Writing a 1 to offset 0x100+4n sets the enable bit of that source, and writing a 1 to 0x180+4n clears it. Zeros have no effect. Both offsets read the current enable bits.
- R5: Offsets for source words beyond the implemented count read zero, even after all ones are written. Unmapped offsets also read zero.
- R6: Offsets 0x200+4n (set) and 0x280+4n (clear) change pending state with the same write-one rule. Set writes to IDs 0..15 are ignored. IDs 0..15 read as pending when any CPU has that software interrupt pending. A clear write to IDs 0..15 clears that interrupt for every CPU.
- R7: A peripheral input that is high at a clock edge sets the pending bit of ID 16+j. While the input stays high, the bit stays set even when a clear is written.
- R8: Priority is one byte per source at 0x400+ID. A write changes only the bytes whose strobe is set.
- R9: The target mask of source k is 8 bits at offset 0x800+4*(k/4), bits 8*(k%4)+7:8*(k%4). Bit c routes peripheral sources to CPU c. Mask bits above the CPU count read zero.
- R10: A write to 0xF00 raises software interrupt bits 3:0 on every CPU c whose bit 16+c is set, but only if bit 15 equals that ID's group bit. Otherwise the write is ignored.
- R11: Each CPU port presents the qualifying source with the lowest priority value, and equal values go to the lower ID. It reflects the state one clock after that state changes. A source qualifies when it is enabled, its group is enabled, and it is pending for that CPU.
- R12: When no source qualifies for a CPU, its port shows ID 1023 with priority 0xFF.
- R13: Read data is registered. It appears on the edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_SRC-16 | Peripheral interrupt lines for IDs 16 and up |
| cpu_id | output | 10*NUM_CPU | Winning ID per CPU, 1023 when none |
| cpu_prio | output | 8*NUM_CPU | Priority of the winning ID per CPU |

## Verification
A corrupted enable, group, pending or priority bit shows up in two ways. It is visible on the next register read of its word, and it reaches the CPU ports one clock after the state changes, as a wrong winner or a spurious 1023. A wrong target or software-pending bit affects only the CPU it belongs to, so every check compares all CPU ports, after several pending patterns and under each group-enable setting. A byte-strobe or decode fault damages a neighbouring source, and full sweeps of the priority and target words read it back.

// File: rtl/irqdist_pkg.sv
package irqdist_pkg;

  localparam int SGI_COUNT = 16;
  localparam int PRIO_W    = 8;
  localparam int ID_W      = 10;

  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  // word offsets (byte offset / 4)
  localparam logic [9:0] W_CTRL   = 10'h000;
  localparam logic [9:0] W_TYPE   = 10'h001;
  localparam logic [9:0] W_GROUP  = 10'h020;
  localparam logic [9:0] W_SETEN  = 10'h040;
  localparam logic [9:0] W_CLREN  = 10'h060;
  localparam logic [9:0] W_SETPND = 10'h080;
  localparam logic [9:0] W_CLRPND = 10'h0A0;
  localparam logic [9:0] W_PRIO   = 10'h100;
  localparam logic [9:0] W_TGT    = 10'h200;
  localparam logic [9:0] W_SGI    = 10'h3C0;

  function automatic logic [31:0] byte_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/irqdist_arb.sv
module irqdist_arb
  import irqdist_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              cand,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
  output logic [ID_W-1:0]                 win_id,
  output logic [PRIO_W-1:0]               win_prio
);

  logic [PRIO_W:0]   best_p;
  logic [ID_W-1:0]   best_id;
  logic [ID_W-1:0]   id_d;
  logic [PRIO_W-1:0] prio_d;

  // linear scan: strict less-than keeps the lower ID on ties
  always_comb begin : select
    best_p  = {1'b1, {PRIO_W{1'b0}}};
    best_id = SPURIOUS_ID;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && ({1'b0, prio[i]} < best_p)) begin
        best_p  = {1'b0, prio[i]};
        best_id = ID_W'(i);
      end
    end
    id_d   = best_id;
    prio_d = best_p[PRIO_W] ? {PRIO_W{1'b1}} : best_p[PRIO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin : regs
    if (!rst_n) begin
      win_id   <= SPURIOUS_ID;
      win_prio <= {PRIO_W{1'b1}};
    end else begin
      win_id   <= id_d;
      win_prio <= prio_d;
    end
  end

  AST_EMPTY_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |=> (win_id == SPURIOUS_ID)); // R12
  AST_SPURIOUS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id == SPURIOUS_ID) |-> (win_prio == {PRIO_W{1'b1}})); // R12
  AST_CAND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |=> (win_id != SPURIOUS_ID)); // R11
  AST_WIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id != SPURIOUS_ID) |-> (win_id < ID_W'(NUM_SRC))); // R11

endmodule

// File: rtl/irqdist_regs.sv
module irqdist_regs
  import irqdist_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [9:0]                             bus_addr,
  input  logic [31:0]                            bus_wdata,
  input  logic [3:0]                             bus_be,
  input  logic                                   bus_wr,
  input  logic                                   bus_rd,
  output logic [31:0]                            bus_rdata,
  input  logic [NUM_SRC-SGI_COUNT-1:0]           irq_in,
  output logic [1:0]                             grp_en,
  output logic [NUM_SRC-1:0]                     src_grp,
  output logic [NUM_SRC-1:0]                     src_en,
  output logic [NUM_SRC-1:SGI_COUNT]             src_pend,
  output logic [NUM_CPU-1:0][SGI_COUNT-1:0]      sgi_pend,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]         src_prio,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]        src_tgt
);

  localparam int NW = NUM_SRC / 32;
  localparam int NQ = NUM_SRC / 4;

  logic [1:0]                          ctrl_q, ctrl_d;
  logic [NUM_SRC-1:0]                  grp_q, grp_d;
  logic [NUM_SRC-1:0]                  en_q, en_d;
  logic [NUM_SRC-1:SGI_COUNT]          pend_q, pend_d;
  logic [NUM_CPU-1:0][SGI_COUNT-1:0]   sgi_q, sgi_d;
  logic [NUM_SRC-1:0][PRIO_W-1:0]      prio_q, prio_d;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]     tgt_q, tgt_d;
  logic [31:0]                         rdata_q, rd_val;
  logic [31:0]                         bm, wbits;
  logic [SGI_COUNT-1:0]                sgi_any;
  logic [3:0]                          sgi_sel;

  always_comb begin : next_state
    bm      = byte_mask(bus_be);
    wbits   = bus_wdata & bm;
    sgi_sel = bus_wdata[3:0];
    ctrl_d  = ctrl_q;
    grp_d   = grp_q;
    en_d    = en_q;
    pend_d  = pend_q;
    sgi_d   = sgi_q;
    prio_d  = prio_q;
    tgt_d   = tgt_q;
    if (bus_wr) begin
      if (bus_addr == W_CTRL) ctrl_d = (ctrl_q & ~bm[1:0]) | wbits[1:0];
      for (int k = 0; k < NUM_SRC; k++) begin
        if (bus_addr == W_GROUP + 10'(k/32) && bm[k%32]) grp_d[k] = bus_wdata[k%32];
        if (bus_addr == W_SETEN + 10'(k/32) && wbits[k%32]) en_d[k] = 1'b1;
        if (bus_addr == W_CLREN + 10'(k/32) && wbits[k%32]) en_d[k] = 1'b0;
      end
      for (int k = SGI_COUNT; k < NUM_SRC; k++) begin
        if (bus_addr == W_SETPND + 10'(k/32) && wbits[k%32]) pend_d[k] = 1'b1;
        if (bus_addr == W_CLRPND + 10'(k/32) && wbits[k%32]) pend_d[k] = 1'b0;
      end
      if (bus_addr == W_CLRPND) begin
        for (int c = 0; c < NUM_CPU; c++) sgi_d[c] = sgi_q[c] & ~wbits[SGI_COUNT-1:0];
      end
      for (int q = 0; q < NQ; q++) begin
        for (int b = 0; b < 4; b++) begin
          if (bus_addr == W_PRIO + 10'(q) && bus_be[b]) prio_d[4*q+b] = bus_wdata[8*b +: PRIO_W];
          if (bus_addr == W_TGT + 10'(q) && bus_be[b])  tgt_d[4*q+b]  = bus_wdata[8*b +: NUM_CPU];
        end
      end
      if (bus_addr == W_SGI && bus_wdata[15] == grp_q[sgi_sel]) begin
        for (int c = 0; c < NUM_CPU; c++) begin
          if (bus_wdata[16+c]) sgi_d[c][sgi_sel] = 1'b1;
        end
      end
    end
    // input wins over a clear in the same cycle
    for (int k = SGI_COUNT; k < NUM_SRC; k++) begin
      if (irq_in[k-SGI_COUNT]) pend_d[k] = 1'b1;
    end
  end

  always_comb begin : sgi_or
    sgi_any = '0;
    for (int c = 0; c < NUM_CPU; c++) sgi_any = sgi_any | sgi_q[c];
  end

  always_comb begin : read_mux
    rd_val = '0;
    if (bus_addr == W_CTRL) rd_val[1:0] = ctrl_q;
    if (bus_addr == W_TYPE) rd_val[7:0] = {3'(NUM_CPU-1), 5'(NW-1)};
    for (int k = 0; k < NUM_SRC; k++) begin
      if (bus_addr == W_GROUP + 10'(k/32)) rd_val[k%32] = grp_q[k];
      if (bus_addr == W_SETEN + 10'(k/32) || bus_addr == W_CLREN + 10'(k/32)) rd_val[k%32] = en_q[k];
    end
    for (int k = 0; k < SGI_COUNT; k++) begin
      if (bus_addr == W_SETPND || bus_addr == W_CLRPND) rd_val[k] = sgi_any[k];
    end
    for (int k = SGI_COUNT; k < NUM_SRC; k++) begin
      if (bus_addr == W_SETPND + 10'(k/32) || bus_addr == W_CLRPND + 10'(k/32)) rd_val[k%32] = pend_q[k];
    end
    for (int q = 0; q < NQ; q++) begin
      for (int b = 0; b < 4; b++) begin
        if (bus_addr == W_PRIO + 10'(q)) rd_val[8*b +: PRIO_W] = prio_q[4*q+b];
        if (bus_addr == W_TGT + 10'(q))  rd_val[8*b +: NUM_CPU] = tgt_q[4*q+b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : state_regs
    if (!rst_n) begin
      ctrl_q  <= '0;
      grp_q   <= '0;
      en_q    <= '0;
      pend_q  <= '0;
      sgi_q   <= '0;
      prio_q  <= '0;
      tgt_q   <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      grp_q  <= grp_d;
      en_q   <= en_d;
      pend_q <= pend_d;
      sgi_q  <= sgi_d;
      prio_q <= prio_d;
      tgt_q  <= tgt_d;
      if (bus_rd) rdata_q <= rd_val;
    end
  end

  assign bus_rdata = rdata_q;
  assign grp_en    = ctrl_q;
  assign src_grp   = grp_q;
  assign src_en    = en_q;
  assign src_pend  = pend_q;
  assign sgi_pend  = sgi_q;
  assign src_prio  = prio_q;
  assign src_tgt   = tgt_q;

  AST_SETEN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == W_SETEN && bus_be[0] && bus_wdata[0]) |=> src_en[0]); // R4
  AST_CLREN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == W_CLREN && bus_be[0] && bus_wdata[0]) |=> !src_en[0]); // R4
  AST_CLRPND_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == W_CLRPND && bus_be[2] && bus_wdata[16] && !irq_in[0]) |=> !src_pend[SGI_COUNT]); // R6
  AST_IRQ_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in[0] |=> src_pend[SGI_COUNT]); // R7
  AST_PRIO_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == W_PRIO && !bus_be[1]) |=> $stable(src_prio[1])); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R13

endmodule

// File: rtl/irqdist_top.sv
module irqdist_top
  import irqdist_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [9:0]                    bus_addr,
  input  logic [31:0]                   bus_wdata,
  input  logic [3:0]                    bus_be,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_SRC-SGI_COUNT-1:0]  irq_in,
  output logic [NUM_CPU*ID_W-1:0]       cpu_id,
  output logic [NUM_CPU*PRIO_W-1:0]     cpu_prio
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin : reset_sync
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [1:0]                          grp_en;
  logic [NUM_SRC-1:0]                  src_grp;
  logic [NUM_SRC-1:0]                  src_en;
  logic [NUM_SRC-1:SGI_COUNT]          src_pend;
  logic [NUM_CPU-1:0][SGI_COUNT-1:0]   sgi_pend;
  logic [NUM_SRC-1:0][PRIO_W-1:0]      src_prio;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]     src_tgt;

  irqdist_regs #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .grp_en    (grp_en),
    .src_grp   (src_grp),
    .src_en    (src_en),
    .src_pend  (src_pend),
    .sgi_pend  (sgi_pend),
    .src_prio  (src_prio),
    .src_tgt   (src_tgt)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] cand;

    always_comb begin : qualify
      for (int i = 0; i < SGI_COUNT; i++) begin
        cand[i] = src_en[i] & grp_en[src_grp[i]] & sgi_pend[c][i];
      end
      for (int i = SGI_COUNT; i < NUM_SRC; i++) begin
        cand[i] = src_en[i] & grp_en[src_grp[i]] & src_pend[i] & src_tgt[i][c];
      end
    end

    irqdist_arb #(
      .NUM_SRC (NUM_SRC)
    ) u_arb (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cand     (cand),
      .prio     (src_prio),
      .win_id   (cpu_id[c*ID_W +: ID_W]),
      .win_prio (cpu_prio[c*PRIO_W +: PRIO_W])
    );
  end

endmodule

// File: tb/sim_irqdist_top.sv
`timescale 1ns/1ps
module sim_irqdist_top;

  localparam int NS = 64;
  localparam int NC = 8;
  localparam int NW = NS / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [9:0]        addr;
  logic [31:0]       wdata;
  logic [3:0]        be;
  logic              wr, rd;
  logic [31:0]       rdata;
  logic [NS-17:0]    irq_in;
  logic [NC*10-1:0]  cpu_id;
  logic [NC*8-1:0]   cpu_prio;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // requirement-level model
  logic [1:0]             m_ctrl;
  logic [NS-1:0]          m_grp, m_en, m_pend;
  logic [NC-1:0][15:0]    m_sgi;
  logic [7:0]             m_prio [NS];
  logic [7:0]             m_tgt  [NS];

  irqdist_top #(.NUM_SRC(NS), .NUM_CPU(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_be(be),
    .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .irq_in(irq_in),
    .cpu_id(cpu_id), .cpu_prio(cpu_prio)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [11:0] a, logic [31:0] d, logic [3:0] b);
    addr = a[11:2]; wdata = d; be = b; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(logic [11:0] a, output logic [31:0] d);
    addr = a[11:2]; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; d = rdata;
  endtask

  task automatic mwr(logic [11:0] a, logic [31:0] d, logic [3:0] b = 4'hF);
    logic [31:0] bm; int w;
    bm = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    w = int'(a[11:2]);
    if (w == 0) m_ctrl = (m_ctrl & ~bm[1:0]) | (d[1:0] & bm[1:0]);
    for (int k = 0; k < NS; k++) begin
      if (w == 32'h20 + k/32 && bm[k%32]) m_grp[k] = d[k%32];
      if (w == 32'h40 + k/32 && bm[k%32] && d[k%32]) m_en[k] = 1'b1;
      if (w == 32'h60 + k/32 && bm[k%32] && d[k%32]) m_en[k] = 1'b0;
      if (w == 32'h80 + k/32 && bm[k%32] && d[k%32] && k >= 16) m_pend[k] = 1'b1;
      if (w == 32'hA0 + k/32 && bm[k%32] && d[k%32]) begin
        m_pend[k] = 1'b0;
        if (k < 16) for (int c = 0; c < NC; c++) m_sgi[c][k] = 1'b0;
      end
      if (w == 32'h100 + k/4 && b[k%4]) m_prio[k] = d[8*(k%4) +: 8];
      if (w == 32'h200 + k/4 && b[k%4]) m_tgt[k]  = d[8*(k%4) +: 8];
    end
    if (w == 32'h3C0 && d[15] == m_grp[d[3:0]])
      for (int c = 0; c < NC; c++) if (d[16+c]) m_sgi[c][d[3:0]] = 1'b1;
    bwr(a, d, b);
  endtask

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    int w; logic [31:0] v;
    w = int'(a[11:2]); v = '0;
    if (w == 0) v[1:0] = m_ctrl;
    if (w == 1) v[7:0] = {3'(NC-1), 5'(NW-1)};
    for (int k = 0; k < NS; k++) begin
      if (w == 32'h20 + k/32) v[k%32] = m_grp[k];
      if (w == 32'h40 + k/32 || w == 32'h60 + k/32) v[k%32] = m_en[k];
      if (w == 32'h80 + k/32 || w == 32'hA0 + k/32) begin
        if (k < 16) begin
          logic o; o = 1'b0;
          for (int c = 0; c < NC; c++) o = o | m_sgi[c][k];
          v[k%32] = o;
        end else v[k%32] = m_pend[k];
      end
      if (w == 32'h100 + k/4) v[8*(k%4) +: 8] = m_prio[k];
      if (w == 32'h200 + k/4) v[8*(k%4) +: 8] = m_tgt[k];
    end
    return v;
  endfunction

  task automatic rchk(string req, logic [11:0] a);
    logic [31:0] v;
    brd(a, v);
    chk(req, v, exp_rd(a));
  endtask

  function automatic void exp_cpu(int c, output logic [9:0] id, output logic [7:0] pr);
    logic [8:0] bp;
    bp = 9'h100; id = 10'd1023; pr = 8'hFF;
    for (int i = 0; i < NS; i++) begin
      logic q;
      q = m_en[i] && m_ctrl[m_grp[i]] && ((i < 16) ? m_sgi[c][i] : (m_pend[i] && m_tgt[i][c]));
      if (q && {1'b0, m_prio[i]} < bp) begin
        bp = {1'b0, m_prio[i]}; id = 10'(i); pr = m_prio[i];
      end
    end
  endfunction

  task automatic check_cpus(string req);
    logic [9:0] eid; logic [7:0] ep;
    @(posedge clk); @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      exp_cpu(c, eid, ep);
      chk(req, 32'(cpu_id[c*10 +: 10]), 32'(eid));
      chk(req, 32'(cpu_prio[c*8 +: 8]), 32'(ep));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v, held, p0, p1;
    addr = '0; wdata = '0; be = '0; wr = 1'b0; rd = 1'b0; irq_in = '0;
    m_ctrl = '0; m_grp = '0; m_en = '0; m_pend = '0; m_sgi = '0;
    for (int i = 0; i < NS; i++) begin m_prio[i] = '0; m_tgt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_cpus("R1");
    rchk("R1", 12'h000); rchk("R1", 12'h084); rchk("R1", 12'h104);
    rchk("R1", 12'h200); rchk("R1", 12'h43C); rchk("R1", 12'h83C);
    chk("R1", rdata, 32'h0);

    // R2 control and type
    mwr(12'h000, 32'hFFFF_FFFF); rchk("R2", 12'h000);
    rchk("R2", 12'h004);
    mwr(12'h000, 32'h0); rchk("R2", 12'h000);

    // R3 group bits with strobes
    mwr(12'h080, 32'hA5A5_0F0F); mwr(12'h084, 32'h1234_5678, 4'b0110);
    rchk("R3", 12'h080); rchk("R3", 12'h084);

    // R4 enable set/clear sweep
    for (int n = 0; n < NW; n++) begin
      for (int p = 0; p < 4; p++) begin
        logic [11:0] a;
        a = 12'(32'h100 + 4*n);
        mwr(a, 32'h1 << (p*9 + n));
        mwr(a, 32'h0);
        rchk("R4", a); rchk("R4", a + 12'h080);
        mwr(a + 12'h080, 32'(p*32'h0101_0101) | 32'h8000_0000);
        rchk("R4", a);
      end
      mwr(12'(32'h100 + 4*n), 32'hFFFF_FFFF, 4'b1010);
      rchk("R4", 12'(32'h180 + 4*n));
    end

    // R5 unimplemented words and unmapped offsets
    for (int n = NW; n < 32; n++) begin
      mwr(12'(32'h100 + 4*n), 32'hFFFF_FFFF);
      rchk("R5", 12'(32'h100 + 4*n));
    end
    rchk("R5", 12'h300); rchk("R5", 12'hC00); rchk("R5", 12'h088);

    // R8 priority bytes
    for (int i = 0; i < NS; i++)
      mwr(12'(32'h400 + 4*(i/4)), 32'((i*37+5) & 255) << (8*(i%4)), 4'(1 << (i%4)));
    mwr(12'h408, 32'hDEAD_BEEF, 4'b0100);
    for (int q = 0; q < NS/4; q++) rchk("R8", 12'(32'h400 + 4*q));

    // R9 targets
    for (int i = 0; i < NS; i++)
      mwr(12'(32'h800 + 4*(i/4)), 32'((i*29+3) & 255) << (8*(i%4)), 4'(1 << (i%4)));
    for (int q = 0; q < NS/4; q++) rchk("R9", 12'(32'h800 + 4*q));

    // R6 pending set/clear
    mwr(12'h200, 32'hFFFF_FFFF); rchk("R6", 12'h200);
    mwr(12'h204, 32'h8001_0010); rchk("R6", 12'h204);
    mwr(12'h284, 32'h0001_0000); rchk("R6", 12'h284);
    mwr(12'h280, 32'hFFFF_FFFF); mwr(12'h284, 32'hFFFF_FFFF);
    rchk("R6", 12'h200); rchk("R6", 12'h204);

    // R7 peripheral inputs: pulse, then held level against a clear
    irq_in[5] = 1'b1; @(posedge clk); @(negedge clk); irq_in[5] = 1'b0;
    m_pend[21] = 1'b1;
    rchk("R7", 12'h200);
    irq_in[5] = 1'b1;
    mwr(12'h280, 32'h0020_0000); m_pend[21] = 1'b1;
    rchk("R7", 12'h200);
    irq_in[5] = 1'b0;
    mwr(12'h280, 32'h0020_0000);
    rchk("R7", 12'h200);

    // R10 software interrupts
    mwr(12'h080, 32'h0);
    mwr(12'hF00, 32'h0005_0003);
    mwr(12'hF00, 32'h0002_8004);
    rchk("R10", 12'h200);
    mwr(12'h000, 32'h3); mwr(12'h100, 32'h0000_0018);
    check_cpus("R10");
    mwr(12'h080, 32'h0000_0010);
    mwr(12'hF00, 32'h0002_8004);
    check_cpus("R10");
    mwr(12'h280, 32'h0000_0008);
    check_cpus("R10");
    rchk("R10", 12'h280);

    // R11 / R12 arbitration patterns over all CPUs
    for (int p = 0; p < 8; p++) begin
      mwr(12'h280, 32'hFFFF_FFFF); mwr(12'h284, 32'hFFFF_FFFF);
      mwr(12'h100, 32'hFFFF_FFFF); mwr(12'h104, 32'hFFFF_FFFF);
      p0 = '0; p1 = '0;
      for (int i = 16; i < NS; i++) begin
        if (((i*7 + p*3) % 5) == 0) begin
          if (i < 32) p0[i] = 1'b1; else p1[i-32] = 1'b1;
        end
      end
      mwr(12'h200, p0); mwr(12'h204, p1);
      mwr(12'hF00, (32'((p*53+1) & 255) << 16) |
                   (32'(m_grp[p] ^ (p == 5)) << 15) | 32'(p));
      mwr(12'h000, 32'(p % 4));
      check_cpus("R11 R12");
    end

    // R11 equal priority resolves to lower ID
    mwr(12'h280, 32'hFFFF_FFFF); mwr(12'h284, 32'hFFFF_FFFF);
    mwr(12'h428, 32'h0000_0010, 4'b0001);
    mwr(12'h430, 32'h0000_1000, 4'b0010);
    mwr(12'h828, 32'h0000_00FF, 4'b0001);
    mwr(12'h830, 32'h0000_FF00, 4'b0010);
    mwr(12'h204, 32'h0004_0100);
    mwr(12'h000, 32'h3);
    check_cpus("R11");
    mwr(12'h000, 32'h2);
    check_cpus("R11");
    mwr(12'h000, 32'h0);
    check_cpus("R12");

    // R13 read data holds between reads
    brd(12'h104, held);
    mwr(12'h184, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    chk("R13", rdata, held);
    rchk("R13", 12'h104);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule